// File: doc/BRIEF.md
# Brightness Ramp and Dither Path

This block turns a brightness request into the value that drives a bank of LED current sinks. The request is a 16-bit level taken either from a software-written register or from the duty cycle that a PWM-input measurement circuit reports. A two-bit selector picks the source. The two unused selector codes freeze the path where it stands.

When the requested level changes, the output does not jump. It travels to the new level in equal-sized moves, one move per 1 ms timebase tick. A three-bit code sets the total travel time and can also bypass the ramp. The 16-bit ramp value is presented as the applied duty. It is also reduced to a 12-bit current code that feeds all sink outputs. Before that reduction, optional temporal dither of 1 to 4 bits lets the average code keep the precision of the discarded low bits.

Top module: `brt_path`

## Requirements
- R1: Under reset, `duty_out` and `cur_code` are 0, the ramp has no pending ticks and the dither frame counter is 0.
- R2: With `src_sel` = 0 the target is `meas_duty`, and with `src_sel` = 2 the target is `reg_brt`. The source that is not selected has no effect on the output.
- R3: With `src_sel` = 1 or 3, `duty_out` keeps its value: ticks do not advance the ramp and changes to either source are not taken up.
- R4: With `slope_sel` = 0, a new target appears on `duty_out` at the clock edge that sees the change.
- R5: `slope_sel` codes 1..7 give ramp lengths of 1, 2, 50, 100, 200, 300 and 500 ticks. `duty_out` equals the target exactly on the last tick and not on any earlier tick (unless the truncated moves land there early).
- R6: On each tick of a ramp, `duty_out` moves by (target − current) / ticks_left, truncated toward zero, and ticks_left then drops by one.
- R7: A target change seen at any clock edge, including one in the middle of a ramp, restarts the ramp from the present `duty_out` with the full length given by the present `slope_sel`. A tick in that same cycle is not applied.
- R8: In a cycle without a tick and without a target change, `duty_out` does not change.
- R9: With dither off (`dither_sel` = 0), `cur_code` equals `duty_out[15:4]` one clock after `duty_out` takes that value.
- R10: With `dither_sel` = N (1..4), a 4-bit frame counter advances on each tick. `cur_code` is `duty_out[15:4]` + 1 when the counter's low N bits are below `duty_out[3:4−N]`, and `duty_out[15:4]` otherwise. Over 2^N consecutive frames the codes therefore sum to 2^N·`duty_out[15:4]` + `duty_out[3:4−N]`.
- R11: Dither never raises the current code past 0xFFF.
- R12: `dither_sel` codes 5..7 act as dither off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_brt | input | 16 | Register-written brightness level |
| meas_duty | input | 16 | Duty measured on the PWM input |
| src_sel | input | 2 | Source select: 0 measured, 2 register, 1/3 hold |
| slope_sel | input | 3 | Ramp length code (0 = bypass) |
| dither_sel | input | 3 | Dither depth code (0 = off, 1..4 bits) |
| tick_1ms | input | 1 | One-cycle pulse per 1 ms step and dither frame |
| duty_out | output | 16 | Applied duty level, also the duty diagnostic |
| cur_code | output | 12 | Current code for all sinks, also the current diagnostic |

## Verification
The ramp is driven with rising and falling targets at every length code. The checks show that the landing happens exactly on the last tick, which catches a wrong tick count or an early finish. A retarget in the middle of a ramp, using a distance that the length does not divide, separates a correct restart-from-current with truncated moves from designs that keep the old step or the old origin. Cycles without ticks and cycles with reserved selector codes show that the output is frozen. Dither is tried with fractions that are zero, partial and full at each depth, and at the saturated top code, and the per-frame codes are summed. This sum tells a correct fraction extraction and comparison apart from off-by-one phases or a wrong bit slice.

// File: rtl/brt_pkg.sv
package brt_pkg;

    localparam int DUTY_W  = 16;
    localparam int CODE_W  = 12;
    localparam int FRAC_W  = DUTY_W - CODE_W;
    localparam int TICK_W  = 10;
    localparam int SRC_W   = 2;
    localparam int SLOPE_W = 3;
    localparam int DITH_W  = 3;

    typedef enum logic [SRC_W-1:0] {
        SRC_MEAS = 2'd0,
        SRC_RSV1 = 2'd1,
        SRC_REG  = 2'd2,
        SRC_RSV3 = 2'd3
    } src_e;

    typedef struct packed {
        logic              valid;
        logic [DUTY_W-1:0] value;
    } target_t;

    typedef struct packed {
        logic [DUTY_W-1:0] goal;
        logic [DUTY_W-1:0] level;
        logic [TICK_W-1:0] left;
    } ramp_t;

    // Ramp length in timebase ticks for each slope code.
    function automatic logic [TICK_W-1:0] slope_ticks(input logic [SLOPE_W-1:0] code);
        logic [TICK_W-1:0] n;
        case (code)
            3'd1:    n = TICK_W'(1);
            3'd2:    n = TICK_W'(2);
            3'd3:    n = TICK_W'(50);
            3'd4:    n = TICK_W'(100);
            3'd5:    n = TICK_W'(200);
            3'd6:    n = TICK_W'(300);
            3'd7:    n = TICK_W'(500);
            default: n = '0;
        endcase
        return n;
    endfunction

    // Dither depth in bits; unsupported codes mean off.
    function automatic logic [DITH_W-1:0] dither_bits(input logic [DITH_W-1:0] code);
        return (int'(code) <= FRAC_W) ? code : '0;
    endfunction

endpackage

// File: rtl/brt_src_mux.sv
module brt_src_mux
    import brt_pkg::*;
(
    input  logic [DUTY_W-1:0] reg_brt,
    input  logic [DUTY_W-1:0] meas_duty,
    input  logic [SRC_W-1:0]  src_sel,
    output target_t           tgt
);
    src_e sel;

    always_comb begin
        sel = src_e'(src_sel);
        tgt = '0;
        case (sel)
            SRC_MEAS: begin
                tgt.valid = 1'b1;
                tgt.value = meas_duty;
            end
            SRC_REG: begin
                tgt.valid = 1'b1;
                tgt.value = reg_brt;
            end
            default: begin
                tgt.valid = 1'b0;
                tgt.value = '0;
            end
        endcase
    end
endmodule

// File: rtl/brt_ramp.sv
module brt_ramp
    import brt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  target_t            tgt,
    input  logic [SLOPE_W-1:0] slope_sel,
    input  logic               tick,
    output ramp_t              st,
    output logic               restart
);
    logic [DUTY_W:0]   diff;
    logic [DUTY_W:0]   mag;
    logic [DUTY_W:0]   quo;
    logic [DUTY_W-1:0] level_nxt;
    logic [TICK_W-1:0] len;

    assign restart = tgt.valid && (tgt.value != st.goal);
    assign len     = slope_ticks(slope_sel);

    always_comb begin
        diff = {1'b0, st.goal} - {1'b0, st.level};
        mag  = diff[DUTY_W] ? (~diff + 1'b1) : diff;
        if (st.left != '0)
            quo = mag / {{(DUTY_W + 1 - TICK_W){1'b0}}, st.left};
        else
            quo = '0;
        if (diff[DUTY_W])
            level_nxt = st.level - quo[DUTY_W-1:0];
        else
            level_nxt = st.level + quo[DUTY_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (restart) begin
            st.goal <= tgt.value;
            if (len == '0) begin
                st.level <= tgt.value;
                st.left  <= '0;
            end else begin
                st.left  <= len;
            end
        end else if (tick && tgt.valid && (st.left != '0)) begin
            st.level <= level_nxt;
            st.left  <= st.left - 1'b1;
        end
    end
endmodule

// File: rtl/brt_dither.sv
module brt_dither
    import brt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DUTY_W-1:0] level,
    input  logic [DITH_W-1:0] dither_sel,
    input  logic              tick,
    output logic [CODE_W-1:0] code
);
    logic [FRAC_W-1:0] frame;
    logic [DITH_W-1:0] nb;
    logic [FRAC_W-1:0] mask;
    logic [FRAC_W-1:0] frac;
    logic [FRAC_W-1:0] phase;
    logic [CODE_W-1:0] base;
    logic              bump;

    always_comb begin
        nb    = dither_bits(dither_sel);
        mask  = FRAC_W'((1 << nb) - 1);
        frac  = level[FRAC_W-1:0] >> (FRAC_W - int'(nb));
        phase = frame & mask;
        base  = level[DUTY_W-1:FRAC_W];
        bump  = (nb != '0) && (phase < frac) && (base != '1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame <= '0;
            code  <= '0;
        end else begin
            if (tick)
                frame <= frame + 1'b1;
            code <= base + CODE_W'(bump);
        end
    end
endmodule

// File: rtl/brt_path.sv
module brt_path
    import brt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [DUTY_W-1:0]  reg_brt,
    input  logic [DUTY_W-1:0]  meas_duty,
    input  logic [SRC_W-1:0]   src_sel,
    input  logic [SLOPE_W-1:0] slope_sel,
    input  logic [DITH_W-1:0]  dither_sel,
    input  logic               tick_1ms,
    output logic [DUTY_W-1:0]  duty_out,
    output logic [CODE_W-1:0]  cur_code
);
    target_t           tgt;
    ramp_t             st;
    logic              restart;
    logic [DUTY_W-1:0] goal;
    logic [TICK_W-1:0] left;

    brt_src_mux i_mux (
        .reg_brt   (reg_brt),
        .meas_duty (meas_duty),
        .src_sel   (src_sel),
        .tgt       (tgt)
    );

    brt_ramp i_ramp (
        .clk       (clk),
        .rst       (rst),
        .tgt       (tgt),
        .slope_sel (slope_sel),
        .tick      (tick_1ms),
        .st        (st),
        .restart   (restart)
    );

    brt_dither i_dither (
        .clk        (clk),
        .rst        (rst),
        .level      (st.level),
        .dither_sel (dither_sel),
        .tick       (tick_1ms),
        .code       (cur_code)
    );

    assign duty_out = st.level;
    assign goal     = st.goal;
    assign left     = st.left;
endmodule

// File: rtl/brt_path_chk.sv
module brt_path_chk
    import brt_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [SRC_W-1:0]   src_sel,
    input logic [SLOPE_W-1:0] slope_sel,
    input logic               tick_1ms,
    input logic [DUTY_W-1:0]  duty_out,
    input logic [CODE_W-1:0]  cur_code,
    input logic               restart,
    input logic [DUTY_W-1:0]  goal,
    input logic [TICK_W-1:0]  left
);
    logic src_ok;
    assign src_ok = (src_sel == 2'd0) || (src_sel == 2'd2);

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !src_ok |=> $stable(duty_out));

    assert_bypass_R4: assert property (@(posedge clk) disable iff (rst)
        (restart && slope_sel == 3'd0) |=> (duty_out == goal));

    assert_land_R5: assert property (@(posedge clk) disable iff (rst)
        (tick_1ms && !restart && src_ok && left == TICK_W'(1)) |=> (duty_out == $past(goal)));

    assert_still_R8: assert property (@(posedge clk) disable iff (rst)
        (!tick_1ms && !restart) |=> $stable(duty_out));

    assert_code_near_R10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cur_code == $past(duty_out[DUTY_W-1:FRAC_W]) ||
                  cur_code == $past(duty_out[DUTY_W-1:FRAC_W]) + 1'b1));
endmodule

bind brt_path brt_path_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .src_sel   (src_sel),
    .slope_sel (slope_sel),
    .tick_1ms  (tick_1ms),
    .duty_out  (duty_out),
    .cur_code  (cur_code),
    .restart   (restart),
    .goal      (goal),
    .left      (left)
);

// File: tb/test_brt_path.sv
module test_brt_path;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] reg_brt;
    logic [15:0] meas_duty;
    logic [1:0]  src_sel;
    logic [2:0]  slope_sel;
    logic [2:0]  dither_sel;
    logic        tick_1ms;
    logic [15:0] duty_out;
    logic [11:0] cur_code;

    int checks = 0;
    int failures = 0;

    // reference model state
    int m_lvl, m_goal, m_left, m_cnt, m_code;

    always #(CLK_PERIOD/2) clk = ~clk;

    brt_path i_brt_path (
        .clk        (clk),
        .rst        (rst),
        .reg_brt    (reg_brt),
        .meas_duty  (meas_duty),
        .src_sel    (src_sel),
        .slope_sel  (slope_sel),
        .dither_sel (dither_sel),
        .tick_1ms   (tick_1ms),
        .duty_out   (duty_out),
        .cur_code   (cur_code)
    );

    function automatic int slope_n(input int c);
        case (c)
            1: return 1;
            2: return 2;
            3: return 50;
            4: return 100;
            5: return 200;
            6: return 300;
            7: return 500;
            default: return 0;
        endcase
    endfunction

    function automatic int code_of(input int lvl, input int cnt, input int ds);
        int nb, base, frac, ph;
        nb   = (ds <= 4) ? ds : 0;
        base = lvl >> 4;
        if (nb == 0) return base;
        frac = (lvl & 15) >> (4 - nb);
        ph   = cnt % (1 << nb);
        if (ph < frac && base != 4095) return base + 1;
        return base;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one clock: drive tick, step the model on the same edge
    task automatic cyc(input bit tk);
        int  nc, tv;
        bit  v;
        nc = code_of(m_lvl, m_cnt, int'(dither_sel));
        v  = (src_sel == 2'd0) || (src_sel == 2'd2);
        tv = (src_sel == 2'd0) ? int'(meas_duty) : int'(reg_brt);
        tick_1ms = tk;
        @(negedge clk);
        if (v && tv != m_goal) begin
            m_goal = tv;
            if (slope_n(int'(slope_sel)) == 0) begin
                m_lvl  = tv;
                m_left = 0;
            end else begin
                m_left = slope_n(int'(slope_sel));
            end
        end else if (tk && v && m_left != 0) begin
            m_lvl  = m_lvl + (m_goal - m_lvl) / m_left;
            m_left = m_left - 1;
        end
        if (tk) m_cnt = (m_cnt + 1) % 16;
        m_code = nc;
        tick_1ms = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 duty after reset", int'(duty_out), 0);
        chk("R1 code after reset", int'(cur_code), 0);
    endtask

    task automatic t_source;
        slope_sel = 3'd0;
        src_sel = 2'd0; meas_duty = 16'h4321; reg_brt = 16'h1111;
        cyc(0);
        chk("R2 measured source", int'(duty_out), 'h4321);
        reg_brt = 16'h2222; cyc(0);
        chk("R2 unselected register ignored", int'(duty_out), 'h4321);
        src_sel = 2'd2; cyc(0);
        chk("R2 register source", int'(duty_out), 'h2222);
        meas_duty = 16'h7777; cyc(0);
        chk("R2 unselected measured ignored", int'(duty_out), 'h2222);
        cyc(0);
        chk("R9 code follows duty", int'(cur_code), 'h222);
    endtask

    task automatic t_bypass;
        slope_sel = 3'd0; reg_brt = 16'hABCD; cyc(0);
        chk("R4 bypass jump up", int'(duty_out), 'hABCD);
        reg_brt = 16'h0010; cyc(0);
        chk("R4 bypass jump down", int'(duty_out), 'h0010);
    endtask

    task automatic t_short_slopes;
        slope_sel = 3'd0; reg_brt = 16'h0000; cyc(0);
        slope_sel = 3'd1; reg_brt = 16'h8000; cyc(0);
        chk("R7 restart does not move", int'(duty_out), 0);
        cyc(1);
        chk("R5 one-tick ramp lands", int'(duty_out), 'h8000);
        slope_sel = 3'd2; reg_brt = 16'h9001; cyc(0);
        cyc(1);
        chk("R6 two-tick first move", int'(duty_out), 'h8800);
        cyc(1);
        chk("R5 two-tick lands", int'(duty_out), 'h9001);
    endtask

    task automatic t_long_slopes;
        for (int c = 3; c <= 7; c++) begin
            int n;
            logic [15:0] tgt;
            n = slope_n(c);
            tgt = (c % 2 == 1) ? 16'hF000 : 16'h0000;
            slope_sel = 3'(c); reg_brt = tgt; cyc(0);
            for (int i = 0; i < n - 1; i++) cyc(1);
            chk($sformatf("R5 code %0d not early", c), int'(duty_out != tgt), 1);
            chk($sformatf("R6 code %0d path", c), int'(duty_out), m_lvl);
            cyc(1);
            chk($sformatf("R5 code %0d lands", c), int'(duty_out), int'(tgt));
        end
    endtask

    task automatic t_retarget_and_still;
        slope_sel = 3'd0; reg_brt = 16'h0000; cyc(0);
        slope_sel = 3'd4; reg_brt = 16'hC800; cyc(0);
        for (int i = 0; i < 40; i++) cyc(1);
        chk("R6 linear mid ramp", int'(duty_out), 40 * 512);
        for (int i = 0; i < 5; i++) cyc(0);
        chk("R8 no tick no change", int'(duty_out), 40 * 512);
        reg_brt = 16'h1000; cyc(1);
        chk("R7 tick ignored on restart", int'(duty_out), 40 * 512);
        cyc(1);
        chk("R7 first move from current", int'(duty_out), 20480 - 163);
        for (int i = 0; i < 98; i++) cyc(1);
        chk("R7 full length applies", int'(duty_out != 16'h1000), 1);
        cyc(1);
        chk("R7 lands after full length", int'(duty_out), 'h1000);
    endtask

    task automatic t_reserved;
        slope_sel = 3'd3; reg_brt = 16'h5000; cyc(0);
        for (int i = 0; i < 10; i++) cyc(1);
        src_sel = 2'd1; reg_brt = 16'h0123; meas_duty = 16'h0456;
        begin
            int held;
            held = int'(duty_out);
            for (int i = 0; i < 6; i++) cyc(1);
            chk("R3 code 1 holds", int'(duty_out), held);
            src_sel = 2'd3;
            for (int i = 0; i < 6; i++) cyc(1);
            chk("R3 code 3 holds", int'(duty_out), held);
        end
        src_sel = 2'd2; slope_sel = 3'd0; cyc(0);
        chk("R3 resumes on valid code", int'(duty_out), 'h0123);
    endtask

    task automatic t_dither_depth(input int ds, input logic [15:0] val, input string req);
        int sum, exp_sum, nb, frames;
        slope_sel = 3'd0; reg_brt = val; dither_sel = 3'(ds);
        cyc(0); cyc(0);
        nb = (ds <= 4) ? ds : 0;
        frames = 1 << (nb == 0 ? 2 : nb);
        sum = 0;
        for (int f = 0; f < frames; f++) begin
            cyc(1); cyc(0);
            chk({req, " frame code"}, int'(cur_code), m_code);
            sum += int'(cur_code);
        end
        if (nb == 0) exp_sum = frames * (int'(val) >> 4);
        else if ((int'(val) >> 4) == 4095) exp_sum = frames * 4095;
        else exp_sum = frames * (int'(val) >> 4) + ((int'(val) & 15) >> (4 - nb));
        chk({req, " frame sum"}, sum, exp_sum);
    endtask

    task automatic t_dither;
        t_dither_depth(0, 16'h1237, "R9 off");
        t_dither_depth(1, 16'h123F, "R10 1-bit");
        t_dither_depth(2, 16'h1234, "R10 2-bit zero-ish");
        t_dither_depth(3, 16'h1237, "R10 3-bit");
        t_dither_depth(4, 16'h1237, "R10 4-bit");
        t_dither_depth(4, 16'h1230, "R10 4-bit zero frac");
        t_dither_depth(6, 16'h1237, "R12 code 6 off");
        t_dither_depth(7, 16'h123F, "R12 code 7 off");
        t_dither_depth(4, 16'hFFFF, "R11 saturate");
        dither_sel = 3'd0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; tick_1ms = 1'b0;
        reg_brt = '0; meas_duty = '0; src_sel = 2'd2;
        slope_sel = 3'd5; dither_sel = 3'd0;
        m_lvl = 0; m_goal = 0; m_left = 0; m_cnt = 0; m_code = 0;
        repeat (3) @(negedge clk);
        t_reset;
        rst = 1'b0;
        cyc(0);
        t_reset;
        t_source;
        t_bypass;
        t_short_slopes;
        t_long_slopes;
        t_retarget_and_still;
        t_reserved;
        t_dither;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule